// File: doc/BRIEF.md
# Block-scaled FP8 quantizer

The quantizer turns a stream of BF16 numbers into blocks in a block-scaled 8-bit format. It collects 32 consecutive inputs into a local buffer and, while they arrive, tracks the largest magnitude among them. When the block is complete it emits one shared scale byte: an exponent-only power of two with bias 127. It then emits 32 element bytes. Each element byte is the matching input divided by that power of two and encoded as E4M3: sign in bit 7, biased exponent (bias 7) in bits 6:3, and a 3-bit fraction in bits 2:0.

The shared exponent is rounded up. It is the smallest power of two that keeps every scaled element within the largest finite E4M3 magnitude, 448 (code 0x7E). No scaled element can therefore overflow the element format.

Both sides use valid/ready handshakes. Input is taken one element per cycle while the buffer fills. The input side then closes until the last byte of the block has left, so the single buffer is never overwritten while it is being read.

Top module: `mx_blk_quant`

## Requirements
- R1: After reset, and on every cycle of filling, `in_ready` is 1 and `out_valid` is 0; an element is stored on each edge where `in_valid` and `in_ready` are both 1.
- R2: On the cycle after the 32nd element is accepted, `out_valid` is 1 and `out_is_scale` is 1 with the scale byte on `out_data`; the following 32 output bytes carry the elements in input order with `out_is_scale` 0.
- R3: For a block whose largest magnitude is a normal BF16 number with biased exponent e and 7-bit fraction f, the scale byte is e - 8 + (f > 0x60 ? 1 : 0), clamped below at 0x00.
- R4: A normal BF16 element x with biased exponent e, under scale byte c, becomes the E4M3 number with biased exponent e - c + 7. Its fraction is rounded to 3 bits with round-to-nearest-even, and a fraction carry moves the exponent up by one.
- R5: When that biased exponent is 0 or below, the element becomes an E4M3 subnormal, a count of 2^-9 units in bits 2:0 with the sign kept. It is rounded to nearest even, and a result of 8 units reads as the smallest normal 0x08.
- R6: A block whose largest magnitude is zero or a BF16 subnormal gets scale byte 0x00, and each element byte is 0x00 or 0x80 according to the input sign.
- R7: A block with any element whose exponent field is 0xFF (NaN or infinity) gets scale byte 0xFF, and all 32 element bytes are 0x7F.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` and `out_is_scale` hold their values.
- R9: `in_ready` is 0 from the cycle after the 32nd element is accepted until the cycle after the last element byte is taken. Input offered in that window has no effect on any later output.
- R10: A zero or subnormal BF16 element inside a block with a normal maximum becomes 0x00 or 0x80 according to its sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element offered |
| in_ready | output | 1 | Block can take an element |
| in_data | input | 16 | BF16 input element |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Scale byte or E4M3 element byte |
| out_is_scale | output | 1 | Current byte is the block's scale byte |

## Verification
The scale byte is due one cycle after the edge that accepts the 32nd element. Each further byte is due one cycle after the edge that completes the previous output handshake, and `in_ready` comes back one cycle after the final handshake. The bench changes inputs and samples outputs on falling edges, so every sample lands half a period after the rising edge that registered the expected value. The bench also checks the scale marker and `in_ready` at the exact falling edge after the 32nd accept and after the last handshake. A stall window holds `out_ready` low for two cycles with junk input offered, and the bench checks that the held byte does not change. The next block must then come out unaffected by that junk.

// File: rtl/mxq_pkg.sv
package mxq_pkg;

  localparam int BF_W    = 16;
  localparam int BF_EW   = 8;
  localparam int BF_FW   = 7;
  localparam int Q_W     = 8;
  localparam int MAG_W   = BF_W - 1;

  localparam logic [Q_W-1:0] E8_NAN_CODE  = 8'hFF;
  localparam logic [Q_W-1:0] E8_MIN_CODE  = 8'h00;
  localparam logic [6:0]     E4_MAX_MAG   = 7'h7E;
  localparam logic [Q_W-1:0] E4_NAN_CODE  = 8'h7F;
  localparam logic [BF_FW-1:0] FRAC_175   = 7'h60;

  typedef enum logic {ST_FILL, ST_SEND} mxq_state_e;

  // Rounded-up shared exponent, biased by 127, from the magnitude of the
  // block maximum. One extra step when the significand exceeds 1.75.
  function automatic logic [Q_W-1:0] shared_code(input logic [MAG_W-1:0] mag);
    logic [BF_EW-1:0] e;
    logic [BF_FW-1:0] f;
    logic [9:0]       c;
    e = mag[MAG_W-1:BF_FW];
    f = mag[BF_FW-1:0];
    c = {2'b00, e} + {9'd0, (f > FRAC_175)};
    if (e == '0)      return E8_MIN_CODE;
    if (c < 10'd8)    return E8_MIN_CODE;
    c = c - 10'd8;
    if (c > 10'd254)  return 8'd254;
    return c[7:0];
  endfunction

  // One BF16 value divided by 2^(code-127), encoded E4M3 with
  // round-to-nearest-even, subnormals and saturation to +-448.
  function automatic logic [Q_W-1:0] to_e4m3(input logic [BF_W-1:0] x,
                                             input logic [Q_W-1:0]  code);
    logic             s;
    logic [BF_EW-1:0] e;
    logic [BF_FW-1:0] f;
    logic signed [9:0] t;
    logic signed [9:0] sh10;
    logic [3:0]       sh;
    logic [3:0]       mr;
    logic             up;
    logic [15:0]      sig, q, rem, half;
    s = x[BF_W-1];
    e = x[BF_W-2:BF_FW];
    f = x[BF_FW-1:0];
    if (e == '0) return {s, 7'd0};
    t = $signed({2'b00, e}) - $signed({2'b00, code}) + 10'sd7;
    if (t >= 10'sd1) begin
      up = f[3] & ((|f[2:0]) | f[4]);
      mr = {1'b0, f[6:4]} + {3'd0, up};
      if (mr[3]) t = t + 10'sd1;
      if ((t > 10'sd15) || ((t == 10'sd15) && (mr[2:0] == 3'd7)))
        return {s, E4_MAX_MAG};
      return {s, t[3:0], mr[2:0]};
    end
    sh10 = 10'sd5 - t;
    sh   = (sh10 > 10'sd9) ? 4'd9 : sh10[3:0];
    sig  = {8'd0, 1'b1, f};
    q    = sig >> sh;
    rem  = sig & ((16'd1 << sh) - 16'd1);
    half = 16'd1 << (sh - 4'd1);
    up   = (rem > half) || ((rem == half) && q[0]);
    q    = q + {15'd0, up};
    return {s, q[6:0]};
  endfunction

endpackage

// File: rtl/mxq_amax_track.sv
module mxq_amax_track
  import mxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [BF_W-1:0]  din,
  output logic [MAG_W-1:0] amax_mag,
  output logic             amax_special
);

  logic [MAG_W-1:0] mag_in;
  logic             spec_in;

  assign mag_in  = din[MAG_W-1:0];
  assign spec_in = (din[BF_W-2:BF_FW] == '1);

  // Magnitude bits of finite BF16 values order like unsigned integers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amax_mag     <= '0;
      amax_special <= 1'b0;
    end else if (take) begin
      if (first || (mag_in > amax_mag)) amax_mag <= mag_in;
      amax_special <= first ? spec_in : (amax_special | spec_in);
    end
  end

endmodule

// File: rtl/mxq_scale_calc.sv
module mxq_scale_calc
  import mxq_pkg::*;
(
  input  logic [MAG_W-1:0] amax_mag,
  input  logic             amax_special,
  output logic [Q_W-1:0]   scale_code
);

  always_comb begin
    if (amax_special) scale_code = E8_NAN_CODE;
    else              scale_code = shared_code(amax_mag);
  end

endmodule

// File: rtl/mxq_elem_conv.sv
module mxq_elem_conv
  import mxq_pkg::*;
(
  input  logic [BF_W-1:0] din,
  input  logic [Q_W-1:0]  scale_code,
  input  logic            blk_special,
  output logic [Q_W-1:0]  dout
);

  always_comb begin
    if (blk_special) dout = E4_NAN_CODE;
    else             dout = to_e4m3(din, scale_code);
  end

endmodule

// File: rtl/mx_blk_quant.sv
module mx_blk_quant
  import mxq_pkg::*;
#(
  parameter int BLK = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15:0]     in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            out_is_scale
);

  localparam int IDX_W = $clog2(BLK);
  localparam int CNT_W = $clog2(BLK + 1);
  localparam logic [IDX_W-1:0] LAST_IN  = IDX_W'(BLK - 1);
  localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(BLK);

  mxq_state_e       state;
  logic [IDX_W-1:0] fill_cnt;
  logic [CNT_W-1:0] send_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [BF_W-1:0]  buf_q [BLK];

  // Named events used by the logic and the assertions.
  logic take_evt, blk_full_evt, byte_go_evt, last_byte_evt;

  logic [MAG_W-1:0] amax_mag;
  logic             amax_special;
  logic [Q_W-1:0]   scale_code;
  logic [Q_W-1:0]   elem_byte;
  logic [BF_W-1:0]  rd_elem;

  assign in_ready      = (state == ST_FILL);
  assign out_valid     = (state == ST_SEND);
  assign take_evt      = in_valid & in_ready;
  assign blk_full_evt  = take_evt && (fill_cnt == LAST_IN);
  assign byte_go_evt   = out_valid & out_ready;
  assign last_byte_evt = byte_go_evt && (send_idx == LAST_OUT);
  assign out_is_scale  = out_valid && (send_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_FILL;
      fill_cnt <= '0;
      send_idx <= '0;
    end else begin
      if (take_evt) fill_cnt <= blk_full_evt ? '0 : fill_cnt + 1'b1;
      if (blk_full_evt) begin
        state    <= ST_SEND;
        send_idx <= '0;
      end else if (last_byte_evt) begin
        state    <= ST_FILL;
        send_idx <= '0;
      end else if (byte_go_evt) begin
        send_idx <= send_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_evt) buf_q[fill_cnt] <= in_data;
  end

  assign rd_idx  = IDX_W'(send_idx - 1'b1);
  assign rd_elem = buf_q[rd_idx];

  mxq_amax_track u_amax (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take_evt),
    .first        (fill_cnt == '0),
    .din          (in_data),
    .amax_mag     (amax_mag),
    .amax_special (amax_special)
  );

  mxq_scale_calc u_scale (
    .amax_mag     (amax_mag),
    .amax_special (amax_special),
    .scale_code   (scale_code)
  );

  mxq_elem_conv u_conv (
    .din          (rd_elem),
    .scale_code   (scale_code),
    .blk_special  (amax_special),
    .dout         (elem_byte)
  );

  always_comb begin
    if (!out_valid)        out_data = '0;
    else if (out_is_scale) out_data = scale_code;
    else                   out_data = elem_byte;
  end

  // R2: the scale byte leads each block, one cycle after completion.
  a_r2_scale_leads: assert property (@(posedge clk) disable iff (!rst_n)
    blk_full_evt |=> (out_valid && out_is_scale));

  // R8: a stalled byte is held.
  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_is_scale)));

  // R9: input side reopens right after the final byte.
  a_r9_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte_evt |=> (in_ready && !out_valid));

  // R3: the scale keeps the maximum within 448 and is the smallest such.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_is_scale && !amax_special && (amax_mag[MAG_W-1:BF_FW] > 8'd8)) |->
      (((({2'b00, amax_mag[MAG_W-1:BF_FW]} - {2'b00, out_data}) == 10'd8) &&
        (amax_mag[BF_FW-1:0] <= FRAC_175)) ||
       ((({2'b00, amax_mag[MAG_W-1:BF_FW]} - {2'b00, out_data}) == 10'd7) &&
        (amax_mag[BF_FW-1:0] > FRAC_175))));

  // R7: a special block announces itself in the scale byte.
  a_r7_nan_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (out_is_scale && amax_special) |-> (out_data == E8_NAN_CODE));

  // R4: finite blocks never produce the E4M3 NaN pattern.
  a_r4_elem_finite: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_scale && !amax_special) |->
      (out_data[6:0] != E4_NAN_CODE[6:0]));

endmodule

// File: tb/mx_blk_quant_tb_top.sv
`timescale 1ns/100ps
module mx_blk_quant_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic        out_is_scale;

  always #2.5 clk = ~clk;

  mx_blk_quant dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_is_scale(out_is_scale)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [15:0] blk   [32];
  logic [7:0]  got_q [33];

  // {first, second, scale, byte0, byte1, rest}
  localparam int NV = 14;
  localparam logic [63:0] VEC [NV] = '{
    {16'h43E0, 16'h3F80, 8'h7F, 8'h7E, 8'h38, 8'h00},
    {16'h43E1, 16'hC3E1, 8'h80, 8'h76, 8'hF6, 8'h00},
    {16'h3F98, 16'h3F88, 8'h77, 8'h7A, 8'h78, 8'h00},
    {16'h3F98, 16'h3F8C, 8'h77, 8'h7A, 8'h79, 8'h00},
    {16'h43E0, 16'h3FF8, 8'h7F, 8'h7E, 8'h40, 8'h00},
    {16'h43E0, 16'h3C00, 8'h7F, 8'h7E, 8'h04, 8'h00},
    {16'h43E0, 16'hBAC0, 8'h7F, 8'h7E, 8'h81, 8'h00},
    {16'h7F7F, 16'h3F80, 8'hF7, 8'h78, 8'h00, 8'h00},
    {16'h0080, 16'h8080, 8'h00, 8'h40, 8'hC0, 8'h00},
    {16'h0000, 16'h8000, 8'h00, 8'h00, 8'h80, 8'h00},
    {16'h0040, 16'h8001, 8'h00, 8'h00, 8'h80, 8'h00},
    {16'h7FC0, 16'h3F80, 8'hFF, 8'h7F, 8'h7F, 8'h7F},
    {16'h7F80, 16'h0000, 8'hFF, 8'h7F, 8'h7F, 8'h7F},
    {16'h43E0, 16'h8001, 8'h7F, 8'h7E, 8'h80, 8'h00}
  };

  function automatic string vec_tag(input int v);
    case (v)
      0, 1:       return "R3 R4";
      2, 3, 4:    return "R4";
      5, 6:       return "R5";
      7, 8:       return "R3";
      9, 10:      return "R6";
      11, 12:     return "R7";
      default:    return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_block();
    bit rdy_ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (!in_ready || out_valid) rdy_ok = 1'b0;
      in_valid = 1'b1;
      in_data  = blk[i];
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    chk("R1", "ready while filling", {15'd0, rdy_ok}, 16'd1);
    chk("R2", "scale marker after 32nd accept",
        {14'd0, out_valid, out_is_scale}, 16'h0003);
    chk("R9", "ready low after block complete", {15'd0, in_ready}, 16'd0);
  endtask

  task automatic pull_block(input int stall_at);
    logic [7:0] held;
    for (int j = 0; j < 33; j++) begin
      if (j == stall_at) begin
        out_ready = 1'b0;
        held      = out_data;
        in_valid  = 1'b1;
        in_data   = 16'h7FC0;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk("R8", "held byte", {8'd0, out_data}, {8'd0, held});
          chk("R9", "valid held, ready low",
              {14'd0, out_valid, in_ready}, 16'h0002);
        end
        out_ready = 1'b1;
        in_valid  = 1'b0;
      end
      got_q[j] = out_data;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk("R9", "ready back after last byte",
        {14'd0, in_ready, out_valid}, 16'h0002);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset state", {14'd0, in_ready, out_valid}, 16'h0002);

    for (int v = 0; v < NV; v++) begin
      bit pad_ok = 1'b1;
      for (int i = 0; i < 32; i++) blk[i] = '0;
      blk[0] = VEC[v][63:48];
      blk[1] = VEC[v][47:32];
      push_block();
      pull_block(-1);
      chk(vec_tag(v), "scale byte", {8'd0, got_q[0]}, {8'd0, VEC[v][31:24]});
      chk(vec_tag(v), "element 0",  {8'd0, got_q[1]}, {8'd0, VEC[v][23:16]});
      chk(vec_tag(v), "element 1",  {8'd0, got_q[2]}, {8'd0, VEC[v][15:8]});
      for (int j = 3; j < 33; j++) if (got_q[j] !== VEC[v][7:0]) pad_ok = 1'b0;
      chk(vec_tag(v), "filler elements", {15'd0, pad_ok}, 16'd1);
    end

    // R2 order and R5 subnormals: powers of two with alternating signs,
    // maximum 2^7 gives scale 126; element k scales to 2^(k-23).
    for (int k = 0; k < 32; k++)
      blk[k] = {k[0], 8'(k + 103), 7'd0};
    push_block();
    pull_block(10);
    chk("R2", "ordered block scale", {8'd0, got_q[0]}, 16'h007E);
    for (int k = 0; k < 32; k++) begin
      logic [6:0] mag;
      mag = (k >= 17) ? 7'((k - 16) << 3) : (k >= 14) ? 7'(1 << (k - 14)) : 7'd0;
      chk("R2", $sformatf("ordered element %0d", k),
          {8'd0, got_q[k+1]}, {8'd0, k[0], mag});
    end

    // R9: junk offered during the stall must not reach this block.
    for (int i = 0; i < 32; i++) blk[i] = '0;
    blk[0] = 16'h43E0;
    blk[1] = 16'h3F80;
    push_block();
    pull_block(-1);
    chk("R9", "block after junk: scale", {8'd0, got_q[0]}, 16'h007F);
    chk("R9", "block after junk: element 1", {8'd0, got_q[2]}, 16'h0038);
    chk("R9", "block after junk: last element", {8'd0, got_q[32]}, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule